// File: doc/BRIEF.md
# Accumulator Datapath with Ten-Operation Decode

This block is the datapath of a very small processor built around an accumulator. It holds an accumulator register, one general register and a registered output port, and it takes a data word from an input port. Each clock cycle an instruction strobe may present a 4-bit operation code. A valid code selects exactly one destination (accumulator, general register or output port) and the single value that destination takes. The value comes from the input port, from one of the two registers, or from an add, OR, AND or complement result. Every other storage element keeps its value.

The block has no fetch, no program counter and no flags. A surrounding controller or test sequencer drives the code and input word cycle by cycle, and it reads results only through the output port. To see the accumulator, it issues the operation that copies the accumulator to the port. To see the general register, it issues the operation that copies that register to the port. The data width is a parameter.

Top module: `acc_datapath`

## Requirements
- R1: Driving `rst_n` low clears the accumulator, the general register and `out_data` to zero at once, without waiting for a clock edge. After `rst_n` rises, updates are held off for two rising clock edges while the internal release is synchronised.
- R2: With `op_vld` high, codes 1 and 6 load the accumulator from `in_data` on the rising edge.
- R3: Code 2 copies the accumulator into the general register. Code 5 loads the general register from `in_data`.
- R4: Code 3 writes the general register to `out_data`. Code 4 writes the accumulator to `out_data`.
- R5: Code 7 sets the accumulator to accumulator plus general register, modulo 2^W. No carry is kept.
- R6: Code 8 sets the accumulator to the bitwise OR of the accumulator and the general register. Code 9 sets it to their bitwise AND.
- R7: Code 10 replaces the accumulator with its bitwise complement.
- R8: The accumulator keeps its value under codes 2, 3, 4 and 5. The general register keeps its value under every code except 2 and 5.
- R9: `out_data` holds its last written value under every code other than 3 and 4.
- R10: Codes 0 and 11 to 15 change no register and leave `out_data` unchanged.
- R11: While `op_vld` is low, no register and no output changes, whatever the code and input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates on the rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| op_vld | input | 1 | Instruction strobe for this cycle |
| op_code | input | 4 | Operation code, 1 to 10 active |
| in_data | input | W | Input port word |
| out_data | output | W | Registered output port |

## Verification
The hardest conditions to reach are register contents that are only visible through the output port. These are the accumulator after an arithmetic or logic step, and the general register after many cycles of other operations. Reading either one overwrites the port, so proving that a code leaves the port alone has to happen before any read-back. The bench therefore checks the port first and only then issues the copy operations. It uses a 4-bit width, which lets it sweep every pair of accumulator and register values through the add, OR and AND operations.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_GPR  = 2'd2,
    DST_PORT = 2'd3
  } dest_e;

  typedef enum logic [2:0] {
    SRC_IN  = 3'd0,
    SRC_ACC = 3'd1,
    SRC_GPR = 3'd2,
    SRC_ADD = 3'd3,
    SRC_OR  = 3'd4,
    SRC_AND = 3'd5,
    SRC_NOT = 3'd6
  } src_e;

  typedef struct packed {
    dest_e dst;
    src_e  src;
  } ctrl_t;

  localparam int unsigned NUM_DEST = 3;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic       op_vld,
  input  logic [3:0] op_code,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl.dst = DST_NONE;
    ctrl.src = SRC_IN;
    if (op_vld) begin
      unique case (op_code)
        4'd1, 4'd6: begin ctrl.dst = DST_ACC;  ctrl.src = SRC_IN;  end
        4'd2:       begin ctrl.dst = DST_GPR;  ctrl.src = SRC_ACC; end
        4'd3:       begin ctrl.dst = DST_PORT; ctrl.src = SRC_GPR; end
        4'd4:       begin ctrl.dst = DST_PORT; ctrl.src = SRC_ACC; end
        4'd5:       begin ctrl.dst = DST_GPR;  ctrl.src = SRC_IN;  end
        4'd7:       begin ctrl.dst = DST_ACC;  ctrl.src = SRC_ADD; end
        4'd8:       begin ctrl.dst = DST_ACC;  ctrl.src = SRC_OR;  end
        4'd9:       begin ctrl.dst = DST_ACC;  ctrl.src = SRC_AND; end
        4'd10:      begin ctrl.dst = DST_ACC;  ctrl.src = SRC_NOT; end
        default:    begin ctrl.dst = DST_NONE; ctrl.src = SRC_IN;  end
      endcase
    end
  end
endmodule

// File: rtl/acc_result.sv
module acc_result
  import acc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  src_e         src,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] gpr,
  output logic [W-1:0] result
);
  logic [W-1:0] sum;

  assign sum = acc + gpr;

  always_comb begin
    unique case (src)
      SRC_IN:  result = in_data;
      SRC_ACC: result = acc;
      SRC_GPR: result = gpr;
      SRC_ADD: result = sum;
      SRC_OR:  result = acc | gpr;
      SRC_AND: result = acc & gpr;
      SRC_NOT: result = ~acc;
      default: result = in_data;
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_vld,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] out_data
);
  logic         rst_sync_n;
  ctrl_t        ctrl;
  logic [W-1:0] result;
  logic [W-1:0] bank_q [NUM_DEST];
  logic [W-1:0] bank_d [NUM_DEST];
  logic [NUM_DEST-1:0] bank_en;
  logic [W-1:0] acc_q;
  logic [W-1:0] gpr_q;

  acc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_decode u_dec (
    .op_vld  (op_vld),
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  acc_result #(.W(W)) u_res (
    .src     (ctrl.src),
    .in_data (in_data),
    .acc     (acc_q),
    .gpr     (gpr_q),
    .result  (result)
  );

  // Slot 0 is the accumulator, slot 1 the general register, slot 2 the port.
  for (genvar g = 0; g < NUM_DEST; g++) begin : g_bank
    always_comb begin
      bank_en[g] = (ctrl.dst == dest_e'(g + 1));
      bank_d[g]  = bank_en[g] ? result : bank_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank_q[g] <= '0;
      else if (!rst_sync_n) bank_q[g] <= '0;
      else if (bank_en[g]) bank_q[g] <= bank_d[g];
    end
  end

  assign acc_q    = bank_q[0];
  assign gpr_q    = bank_q[1];
  assign out_data = bank_q[2];
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         op_vld,
  input logic [3:0]   op_code,
  input logic [W-1:0] in_data,
  input logic [W-1:0] acc_q,
  input logic [W-1:0] gpr_q,
  input logic [W-1:0] out_data
);
  logic act;
  assign act = op_vld && (op_code >= 4'd1) && (op_code <= 4'd10);

  assert_load_acc_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_vld && (op_code == 4'd1 || op_code == 4'd6)) |=> acc_q == $past(in_data));

  assert_copy_gpr_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_vld && op_code == 4'd2) |=> gpr_q == $past(acc_q));

  assert_port_acc_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_vld && op_code == 4'd4) |=> out_data == $past(acc_q));

  assert_add_wrap_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_vld && op_code == 4'd7) |=> acc_q == W'($past(acc_q) + $past(gpr_q)));

  assert_invert_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_vld && op_code == 4'd10) |=> (acc_q ^ $past(acc_q)) == {W{1'b1}});

  assert_gpr_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(op_vld && (op_code == 4'd2 || op_code == 4'd5)) |=> $stable(gpr_q));

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_vld && op_code >= 4'd2 && op_code <= 4'd5) |=> $stable(acc_q));

  assert_port_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(op_vld && (op_code == 4'd3 || op_code == 4'd4)) |=> $stable(out_data));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !act |=> ($stable(acc_q) && $stable(gpr_q) && $stable(out_data)));
endmodule

bind acc_datapath acc_datapath_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_vld     (op_vld),
  .op_code    (op_code),
  .in_data    (in_data),
  .acc_q      (acc_q),
  .gpr_q      (gpr_q),
  .out_data   (out_data)
);

// File: tb/sim_acc_datapath.sv
`timescale 1ns/1ps
module sim_acc_datapath;
  localparam int TW = 4;
  localparam int M  = 1 << TW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_vld;
  logic [3:0]    op_code;
  logic [TW-1:0] in_data;
  logic [TW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  acc_datapath #(.W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code),
    .in_data(in_data), .out_data(out_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic issue(input int c, input int d);
    op_vld  = 1'b1;
    op_code = 4'(c);
    in_data = TW'(d);
    @(negedge clk);
    op_vld  = 1'b0;
  endtask

  task automatic read_acc(input string req, input int exp);
    issue(4, 0);
    check(req, int'(out_data), exp);
  endtask

  task automatic read_gpr(input string req, input int exp);
    issue(3, 0);
    check(req, int'(out_data), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_vld = 1'b0; op_code = '0; in_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset port", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_acc("R1 reset acc", 0);
    read_gpr("R1 reset gpr", 0);

    // R2: both load codes, every input value
    for (int v = 0; v < M; v++) begin
      issue(1, v);
      read_acc("R2 code1", v);
      issue(6, (v + 7) % M);
      read_acc("R2 code6", (v + 7) % M);
    end

    // R3: load and copy into the general register
    for (int v = 0; v < M; v++) begin
      issue(5, v);
      read_gpr("R3 code5", v);
      issue(1, v ^ 5);
      issue(2, 0);
      read_gpr("R3 code2", v ^ 5);
      read_acc("R8 acc after code2", v ^ 5);
    end

    // R5/R6/R4: exhaustive operand pairs
    for (int a = 0; a < M; a++) begin
      for (int r = 0; r < M; r++) begin
        issue(5, r); issue(1, a); issue(7, 0);
        read_acc("R5 add", (a + r) % M);
        issue(1, a); issue(8, 0);
        read_acc("R6 or", a | r);
        issue(1, a); issue(9, 0);
        read_acc("R6 and", a & r);
        read_gpr("R4 gpr to port", r);
      end
    end

    // R7: complement
    for (int v = 0; v < M; v++) begin
      issue(1, v); issue(10, 0);
      read_acc("R7 not", (~v) & (M - 1));
      issue(10, 0);
      read_acc("R7 not twice", v);
    end

    // R8: accumulator untouched by codes 2..5
    issue(1, 3); issue(5, 9); issue(2, 12); issue(5, 12);
    read_acc("R8 acc hold", 3);
    read_gpr("R8 gpr code5", 12);
    // R8: general register untouched by others
    issue(5, 6);
    issue(1, 2); issue(6, 1); issue(7, 0); issue(8, 0); issue(9, 0); issue(10, 0); issue(4, 0);
    read_gpr("R8 gpr hold", 6);

    // R9: port holds across non-port codes
    issue(1, 11); issue(4, 0);
    check("R4 acc to port", int'(out_data), 11);
    issue(1, 4);  check("R9 after code1", int'(out_data), 11);
    issue(5, 2);  check("R9 after code5", int'(out_data), 11);
    issue(7, 0);  check("R9 after code7", int'(out_data), 11);
    issue(10, 0); check("R9 after code10", int'(out_data), 11);

    // R10: unused codes
    issue(1, 5); issue(5, 10); issue(4, 0);
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c > 10) begin
        issue(c, 15);
        check("R10 port unchanged", int'(out_data), 5);
      end
    end
    read_gpr("R10 gpr unchanged", 10);
    read_acc("R10 acc unchanged", 5);

    // R11: strobe low
    op_vld = 1'b0; op_code = 4'd4; in_data = '0;
    issue(1, 9);
    op_vld = 1'b0;
    for (int c = 1; c <= 10; c++) begin
      op_code = 4'(c); in_data = 4'd15;
      @(negedge clk);
      check("R11 port idle", int'(out_data), 9 == 9 ? 5 : 0);
    end
    read_gpr("R11 gpr idle", 10);
    read_acc("R11 acc idle", 9);

    // R1: asynchronous clear mid-cycle
    issue(5, 7);
    @(posedge clk); #1;
    rst_n = 1'b0; #0.5;
    check("R1 async port clear", int'(out_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // Release takes two edges; an instruction in that window is dropped.
    issue(1, 13);
    @(negedge clk);
    read_acc("R1 release hold", 0);
    read_gpr("R1 gpr cleared", 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule